// File: doc/BRIEF.md
# Floating-point status bit set/clear unit

This block holds a 32-bit floating-point status and control register and carries out the two single-bit move-to-status instructions. One of them forces a chosen bit to 0 and the other forces it to 1. Each instruction arrives as a 32-bit word with a valid strobe. The block decodes the primary and extended opcodes and applies the bit write. In record form it also refreshes a 4-bit condition-register field.

Bits are numbered from the most significant end. Two summary bits, the enabled-exception summary and the invalid-operation summary, are never written directly. They are recomputed from the other status bits on every register update. A parallel load port seeds the register, and both the register and the condition field are outputs. Words that match neither encoding raise a one-cycle illegal flag and leave all state alone.

Top module: `fp_status_bitop`

## Requirements
- R1: An instruction is decoded from big-endian bits 0..5 (word[31:26]) equal to 63 and bits 21..30 (word[10:1]). Extended opcode 70 selects clear (base word 0xfc00008c) and 38 selects set (base word 0xfc00004c). Bits 11..20 are ignored.
- R2: The target index is big-endian bits 6..10 (word[25:21]). Index i acts on register vector bit 31-i, so index 0 is the MSB (FX).
- R3: Clear writes 0 to the selected bit. Every other non-summary bit is unchanged.
- R4: Set writes 1 to the selected bit. Every other non-summary bit is unchanged.
- R5: The summary bits are at big-endian index 1 (FEX, vector bit 30) and index 2 (VX, vector bit 29). Neither an instruction nor the load port writes them directly. After every update, VX is the OR of the bits at big-endian 7..12 and 21..23. FEX is (VX&VE)|(OX&OE)|(UX&UE)|(ZX&ZE)|(XX&XE). Here OX, UX, ZX and XX sit at big-endian 3..6, and VE, OE, UE, ZE and XE sit at big-endian 24..28.
- R6: When word bit 31 (word[0], Rc) is 1, cr1_q is loaded with the updated register's top four bits. The order is cr1_q[3]=FX, [2]=FEX, [1]=VX, [0]=OX.
- R7: When Rc is 0, cr1_q is unchanged.
- R8: A valid word that matches neither encoding pulses illegal for exactly one cycle. It changes neither status_q nor cr1_q and gives no done.
- R9: The register, the condition field and a one-cycle done pulse all change one clock after the valid strobe of an accepted instruction.
- R10: A synchronous reset clears status_q, cr1_q, done and illegal to zero.
- R11: ld_en loads ld_data, with the summary bits recomputed, one clock later. When ld_en is high, a simultaneous instruction is dropped and gives neither done nor illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Parallel load strobe |
| ld_data | input | 32 | Seed value for the register |
| instr_valid | input | 1 | Instruction word valid |
| instr_word | input | 32 | Instruction word |
| status_q | output | 32 | Status and control register |
| cr1_q | output | 4 | Condition-register field 1 |
| done | output | 1 | Accepted-instruction pulse |
| illegal | output | 1 | Unrecognised-word pulse |

## Verification
Every result of this block is due exactly one clock after its stimulus: the register, the condition field, done, illegal and the loaded value. The bench drives inputs on the falling edge and lets one rising edge pass. It samples on the next falling edge, then removes the strobe. Illegal words and reset are checked at the same point, and the bench confirms that the illegal flag has dropped one cycle later. The sweep covers every index, both variants, both record settings and several seed patterns, with expected values computed by a bench model of the summary formulas.

// File: rtl/fpsb_pkg.sv
package fpsb_pkg;

   localparam int FPSB_W = 32;

   typedef enum logic [1:0] {
      FPSB_NONE = 2'd0,
      FPSB_CLR  = 2'd1,
      FPSB_SET  = 2'd2,
      FPSB_BAD  = 2'd3
   } fpsb_op_e;

   // big-endian bit indices
   localparam int BE_FX  = 0;
   localparam int BE_FEX = 1;
   localparam int BE_VX  = 2;
   localparam int BE_OX  = 3;
   localparam int BE_UX  = 4;
   localparam int BE_ZX  = 5;
   localparam int BE_XX  = 6;
   localparam int BE_VE  = 24;
   localparam int BE_OE  = 25;
   localparam int BE_UE  = 26;
   localparam int BE_ZE  = 27;
   localparam int BE_XE  = 28;

   function automatic int be2vec(input int i);
      return FPSB_W - 1 - i;
   endfunction

   function automatic logic calc_vx(input logic [FPSB_W-1:0] s);
      logic r;
      r = 1'b0;
      for (int k = 7; k <= 12; k++) r = r | s[be2vec(k)];
      for (int k = 21; k <= 23; k++) r = r | s[be2vec(k)];
      return r;
   endfunction

   function automatic logic calc_fex(input logic [FPSB_W-1:0] s, input logic vx);
      return (vx              & s[be2vec(BE_VE)]) |
             (s[be2vec(BE_OX)] & s[be2vec(BE_OE)]) |
             (s[be2vec(BE_UX)] & s[be2vec(BE_UE)]) |
             (s[be2vec(BE_ZX)] & s[be2vec(BE_ZE)]) |
             (s[be2vec(BE_XX)] & s[be2vec(BE_XE)]);
   endfunction

endpackage

// File: rtl/fpsb_decode.sv
module fpsb_decode
   import fpsb_pkg::*;
#(
   parameter int INSTR_W  = 32,
   parameter int OPC_W    = 6,
   parameter int IDX_W    = 5,
   parameter int XO_W     = 10,
   parameter int PRIMARY  = 63,
   parameter int XO_CLEAR = 70,
   parameter int XO_SET   = 38
) (
   input  logic               valid,
   input  logic [INSTR_W-1:0] word,
   output fpsb_op_e           op,
   output logic [IDX_W-1:0]   idx,
   output logic               rc
);

   localparam int IDX_TOP = INSTR_W - 1 - OPC_W;

   generate
      if (XO_CLEAR == XO_SET) begin : g_bad_xo
         $error("fpsb_decode: clear and set extended opcodes must differ");
      end
      if (OPC_W + IDX_W + XO_W + 1 > INSTR_W) begin : g_bad_fields
         $error("fpsb_decode: fields exceed instruction width");
      end
   endgenerate

   logic [OPC_W-1:0] opcd;
   logic [XO_W-1:0]  xo;

   assign opcd = word[INSTR_W-1 -: OPC_W];
   assign xo   = word[XO_W:1];
   assign idx  = word[IDX_TOP -: IDX_W];
   assign rc   = word[0];

   always_comb begin
      if (!valid)
         op = FPSB_NONE;
      else if (opcd == OPC_W'(PRIMARY) && xo == XO_W'(XO_CLEAR))
         op = FPSB_CLR;
      else if (opcd == OPC_W'(PRIMARY) && xo == XO_W'(XO_SET))
         op = FPSB_SET;
      else
         op = FPSB_BAD;
   end

   // R1: a decoded clear or set always carries the primary opcode
   always_comb begin
      if (op == FPSB_CLR || op == FPSB_SET)
         p_primary_r1: assert (opcd == OPC_W'(PRIMARY));
   end

endmodule

// File: rtl/fpsb_bitwrite.sv
module fpsb_bitwrite
   import fpsb_pkg::*;
#(
   parameter int W     = 32,
   parameter int IDX_W = 5
) (
   input  logic [W-1:0]     cur,
   input  logic             we,
   input  logic             set_val,
   input  logic [IDX_W-1:0] idx,
   output logic [W-1:0]     nxt
);

   generate
      if (W != FPSB_W) begin : g_bad_w
         $error("fpsb_bitwrite: width must match the status layout");
      end
      if ((1 << IDX_W) < W) begin : g_bad_idx
         $error("fpsb_bitwrite: index too narrow for width");
      end
   endgenerate

   logic [W-1:0] raw;
   logic         vx_s;
   logic         fex_s;

   genvar b;
   generate
      for (b = 0; b < W; b++) begin : g_bit
         localparam int BE = W - 1 - b;
         if (BE == BE_FEX) begin : g_fex
            assign raw[b] = cur[b];
            assign nxt[b] = fex_s;
         end else if (BE == BE_VX) begin : g_vx
            assign raw[b] = cur[b];
            assign nxt[b] = vx_s;
         end else begin : g_plain
            assign raw[b] = (we && idx == IDX_W'(BE)) ? set_val : cur[b];
            assign nxt[b] = raw[b];
         end
      end
   endgenerate

   assign vx_s  = calc_vx(raw);
   assign fex_s = calc_fex(raw, vx_s);

   // R5: with no write pending, ordinary bits pass through untouched
   always_comb begin
      if (!we)
         p_passthru_r5: assert ((nxt & ~32'h6000_0000) == (cur & ~32'h6000_0000));
   end

endmodule

// File: rtl/fp_status_bitop.sv
module fp_status_bitop
   import fpsb_pkg::*;
#(
   parameter int W        = 32,
   parameter int CR_W     = 4,
   parameter int IDX_W    = 5,
   parameter int PRIMARY  = 63,
   parameter int XO_CLEAR = 70,
   parameter int XO_SET   = 38
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ld_en,
   input  logic [31:0]   ld_data,
   input  logic          instr_valid,
   input  logic [31:0]   instr_word,
   output logic [31:0]   status_q,
   output logic [3:0]    cr1_q,
   output logic          done,
   output logic          illegal
);

   generate
      if (W != 32 || CR_W != 4) begin : g_bad_cfg
         $error("fp_status_bitop: port widths fixed at 32 and 4");
      end
   endgenerate

   fpsb_op_e         dec_op;
   logic [IDX_W-1:0] dec_idx;
   logic             dec_rc;
   logic [W-1:0]     ins_nxt;
   logic [W-1:0]     ld_norm;
   logic             ins_we;

   fpsb_decode #(
      .INSTR_W (W),
      .IDX_W   (IDX_W),
      .PRIMARY (PRIMARY),
      .XO_CLEAR(XO_CLEAR),
      .XO_SET  (XO_SET)
   ) dec_u (
      .valid(instr_valid),
      .word (instr_word),
      .op   (dec_op),
      .idx  (dec_idx),
      .rc   (dec_rc)
   );

   assign ins_we = (dec_op == FPSB_CLR) || (dec_op == FPSB_SET);

   fpsb_bitwrite #(.W(W), .IDX_W(IDX_W)) ins_u (
      .cur    (status_q),
      .we     (ins_we),
      .set_val(dec_op == FPSB_SET),
      .idx    (dec_idx),
      .nxt    (ins_nxt)
   );

   fpsb_bitwrite #(.W(W), .IDX_W(IDX_W)) ld_u (
      .cur    (ld_data),
      .we     (1'b0),
      .set_val(1'b0),
      .idx    ('0),
      .nxt    (ld_norm)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         status_q <= '0;
         cr1_q    <= '0;
         done     <= 1'b0;
         illegal  <= 1'b0;
      end else begin
         done    <= 1'b0;
         illegal <= 1'b0;
         if (ld_en) begin
            status_q <= ld_norm;
         end else if (ins_we) begin
            status_q <= ins_nxt;
            done     <= 1'b1;
            if (dec_rc) cr1_q <= ins_nxt[W-1 -: CR_W];
         end else if (dec_op == FPSB_BAD) begin
            illegal <= 1'b1;
         end
      end
   end

   // R5: stored summary bits agree with the other status bits
   p_summary_r5: assert property (@(posedge clk) disable iff (rst)
      status_q[30] == calc_fex(status_q, status_q[29]) && status_q[29] == calc_vx(status_q));

   // R6: record form mirrors the top four status bits
   p_rc_copy_r6: assert property (@(posedge clk) disable iff (rst)
      done && $past(dec_rc) |-> cr1_q == status_q[31:28]);

   // R7: non-record form leaves the condition field alone
   p_rc_hold_r7: assert property (@(posedge clk) disable iff (rst)
      done && !$past(dec_rc) |-> $stable(cr1_q));

   // R8: an illegal word changes no state
   p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      illegal |-> $stable(status_q) && $stable(cr1_q) && !done);

   // R9: done follows a strobe by one cycle with no load in the way
   p_done_origin_r9: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(instr_valid) && !$past(ld_en));

   // R3: clear drives the selected ordinary bit to zero
   p_clear_bit_r3: assert property (@(posedge clk) disable iff (rst)
      done && $past(dec_op == FPSB_CLR) && $past(dec_idx) > 5'd2
      |-> status_q[5'd31 - $past(dec_idx)] == 1'b0);

   // R4: set drives the selected ordinary bit to one
   p_set_bit_r4: assert property (@(posedge clk) disable iff (rst)
      done && $past(dec_op == FPSB_SET) && $past(dec_idx) > 5'd2
      |-> status_q[5'd31 - $past(dec_idx)] == 1'b1);

   // R11: a load in the same cycle suppresses instruction results
   p_load_wins_r11: assert property (@(posedge clk) disable iff (rst)
      ld_en |=> !done && !illegal);

endmodule

// File: tb/fp_status_bitop_tb_top.sv
module fp_status_bitop_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ld_en = 1'b0;
   logic [31:0] ld_data = '0;
   logic        instr_valid = 1'b0;
   logic [31:0] instr_word = '0;
   logic [31:0] status_q;
   logic [3:0]  cr1_q;
   logic        done;
   logic        illegal;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic [31:0] m_stat;
   logic [3:0]  m_cr;

   always #2 clk = ~clk;

   fp_status_bitop dut_i (
      .clk(clk), .rst(rst), .ld_en(ld_en), .ld_data(ld_data),
      .instr_valid(instr_valid), .instr_word(instr_word),
      .status_q(status_q), .cr1_q(cr1_q), .done(done), .illegal(illegal)
   );

   function automatic logic [31:0] norm(input logic [31:0] v);
      logic vx, fex;
      logic [31:0] r;
      vx = 1'b0;
      for (int k = 7; k <= 12; k++) vx = vx | v[31-k];
      for (int k = 21; k <= 23; k++) vx = vx | v[31-k];
      fex = 1'b0;
      for (int k = 0; k < 4; k++) fex = fex | (v[31-(3+k)] & v[31-(25+k)]);
      fex = fex | (vx & v[31-24]);
      r = v;
      r[30] = fex;
      r[29] = vx;
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_load(input logic [31:0] v);
      @(negedge clk);
      ld_en = 1'b1; ld_data = v;
      @(posedge clk);
      @(negedge clk);
      ld_en = 1'b0;
      m_stat = norm(v);
      chk("R11 load value", status_q, m_stat);
   endtask

   task automatic do_instr(input bit setv, input int idx, input bit rc);
      logic [31:0] w;
      w = setv ? 32'hfc00004c : 32'hfc00008c;
      w[25:21] = idx[4:0];
      w[0] = rc;
      w[15:11] = 5'h15;  // ignored field, R1
      @(negedge clk);
      instr_valid = 1'b1; instr_word = w;
      @(posedge clk);
      @(negedge clk);
      instr_valid = 1'b0;
      if (idx != 1 && idx != 2) m_stat[31-idx] = setv;
      m_stat = norm(m_stat);
      if (rc) m_cr = m_stat[31:28];
      if (setv) chk("R4 R2 set result", status_q, m_stat);
      else      chk("R3 R2 clear result", status_q, m_stat);
      if (rc) chk("R6 cr copy", {28'd0, cr1_q}, {28'd0, m_cr});
      else    chk("R7 cr hold", {28'd0, cr1_q}, {28'd0, m_cr});
      chk("R9 done pulse", {31'd0, done}, 32'd1);
      chk("R1 no illegal", {31'd0, illegal}, 32'd0);
   endtask

   task automatic do_bad(input logic [31:0] w);
      @(negedge clk);
      instr_valid = 1'b1; instr_word = w;
      @(posedge clk);
      @(negedge clk);
      instr_valid = 1'b0;
      chk("R8 illegal raised", {31'd0, illegal}, 32'd1);
      chk("R8 no done", {31'd0, done}, 32'd0);
      chk("R8 status kept", status_q, m_stat);
      chk("R8 cr kept", {28'd0, cr1_q}, {28'd0, m_cr});
      @(negedge clk);
      chk("R8 one-cycle pulse", {31'd0, illegal}, 32'd0);
   endtask

   initial begin
      logic [31:0] seeds [4];
      seeds[0] = 32'h0000_0000;
      seeds[1] = 32'hFFFF_FFFF;
      seeds[2] = 32'h1200_0088;
      seeds[3] = 32'h0080_0010;
      m_stat = '0; m_cr = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R10 reset status", status_q, 32'd0);
      chk("R10 reset cr", {28'd0, cr1_q}, 32'd0);
      chk("R10 reset done", {31'd0, done}, 32'd0);
      chk("R10 reset illegal", {31'd0, illegal}, 32'd0);

      // R5: summary bits in load data are ignored
      do_load(32'h6000_0000);
      chk("R5 summary not loaded", status_q, 32'd0);

      for (int s = 0; s < 4; s++)
         for (int op = 0; op < 2; op++)
            for (int i = 0; i < 32; i++)
               for (int rc = 0; rc < 2; rc++) begin
                  do_load(seeds[s]);
                  do_instr(op[0], i, rc[0]);
               end

      // R5: set one invalid bit and one enable, summaries follow
      do_load(32'h0);
      do_instr(1'b1, 8, 1'b1);
      chk("R5 vx from invalid bit", {31'd0, status_q[29]}, 32'd1);
      do_instr(1'b1, 24, 1'b1);
      chk("R5 fex from enable", {31'd0, status_q[30]}, 32'd1);
      chk("R6 cr summary bits", {28'd0, cr1_q}, 32'h6);

      // R8: words matching neither encoding
      do_bad(32'hfc00008e);
      do_bad(32'h7c00008c);
      do_bad(32'h0000_0000);

      // R11: load and instruction together, load wins
      @(negedge clk);
      ld_en = 1'b1; ld_data = 32'h0000_0100;
      instr_valid = 1'b1; instr_word = 32'hfc00004d;
      @(posedge clk);
      @(negedge clk);
      ld_en = 1'b0; instr_valid = 1'b0;
      m_stat = norm(32'h0000_0100);
      chk("R11 load priority status", status_q, m_stat);
      chk("R11 instruction dropped", {30'd0, done, illegal}, 32'd0);
      chk("R11 cr untouched", {28'd0, cr1_q}, {28'd0, m_cr});

      // R10: reset mid-run
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk("R10 mid reset status", status_q, 32'd0);
      chk("R10 mid reset cr", {28'd0, cr1_q}, 32'd0);

      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule